// File: doc/BRIEF.md
# Receive Buffer Descriptor Scatter Engine

This block takes one incoming frame at a time as a byte stream and stores it in memory through a ring of 8-byte receive descriptors. After the last data byte it appends a 4-byte CRC-32. The combined image is split across as many descriptor buffers as it needs. A programmable buffer size caps how many bytes go into any one buffer. Every descriptor it fills is written back with its byte count and with the empty flag cleared. The descriptor that ends the frame also carries the last flag and any error flags.

Software builds the ring in memory and sets the empty flag on descriptors that are free. It then raises the controller enable and pulses receive-activate. The engine keeps a receive-enabled status taken from the empty flag of the descriptor it points at. While that status is clear, it will not start a frame. Two size rules apply. A fixed hardware maximum truncates the stored frame. A software limit only raises a length-error flag.

Top module: `rx_scatter_engine`

## Requirements
- R1: After reset, and at any time receive is not enabled (`rx_on` = 0), the engine holds `s_ready` low and takes no byte of a new frame.
- R2: With `ctl_en` = 1 and `rx_on` = 0, a `rx_kick` pulse reads word 0 of the current descriptor and sets `rx_on` to its bit 31 (empty). A kick on a descriptor that is not empty leaves `rx_on` at 0.
- R3: One cycle after `ctl_en` is seen low, `rx_on` is 0. While `ctl_en` is low, the current descriptor pointer returns to `ring_base`.
- R4: The stored image is all kept data bytes in arrival order, then the CRC-32 of all data bytes, most significant byte first. The CRC is reflected, uses polynomial 0xEDB88320, starts from all ones and is inverted at the end. Image byte k of a buffer goes to buffer address + k, as a single-lane write on lane k mod 4 with the byte repeated on all four lanes.
- R5: The buffer size in use is `max_buf` with bits 3:0 and 15:11 forced to zero.
- R6: A buffer is closed as soon as it holds the buffer size in bytes. When fewer than 4 bytes remain, the CRC bytes continue in the next buffer.
- R7: A descriptor is word 0 at offset 0 and the buffer address at offset 4. Word 0 holds flags: 31 empty, 29 wrap, 27 last, 21 length error, 16 truncated. Bits 15:0 hold the length. Write-back puts the byte count in bits 15:0, clears bit 31 and keeps the wrap bit. It sets bit 27 only on the descriptor that ends the frame.
- R8: `ev_buf` pulses for one cycle for each descriptor closed before the end of the frame. `ev_frame` pulses for one cycle for the final one. The two never pulse together.
- R9: If data length + 4 exceeds `MAX_FRAME`, only the first `MAX_FRAME`−4 data bytes are kept, followed by the CRC. The final descriptor gets bits 16 and 21.
- R10: If the stored size (kept data + 4) exceeds `len_limit`, the final descriptor gets bit 21.
- R11: The next descriptor is at the current one + 8, or at `ring_base` when the wrap bit is set. At the end of a frame, `rx_on` takes the empty flag of the new current descriptor.
- R12: If a descriptor without the empty flag is reached in the middle of a frame, the rest of the frame is consumed and discarded. No `ev_frame` pulse is given, and that descriptor is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable |
| rx_kick | input | 1 | Receive-activate pulse |
| ring_base | input | AW | Byte address of the first ring descriptor |
| max_buf | input | 16 | Buffer size in bytes (bits 10:4 used) |
| len_limit | input | 16 | Software frame size limit for length error |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of frame |
| s_ready | output | 1 | Engine takes the stream byte |
| mem_rd | output | 1 | Word read strobe; data returns on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| rx_on | output | 1 | Receive-enabled status |
| ev_buf | output | 1 | Buffer-received event pulse |
| ev_frame | output | 1 | Frame-received event pulse |

## Verification
Several patterns of frame length against buffer size are sent through the engine:
- a frame that fits in one buffer;
- a frame that ends with CRC bytes on both sides of a buffer boundary;
- a frame that fills a buffer exactly on its last CRC byte at the wrapping descriptor.

Telling these apart shows whether buffers close on the right byte and whether the last flag lands only on the final descriptor. A frame over the software limit but under the hardware maximum isolates the length-error rule from the truncation rule. A longer frame then exercises both.

A ring with one free descriptor followed by an occupied one tests the mid-frame drop. Toggling the enable and then programming an unaligned buffer size check the pointer return and the size masking.

// File: rtl/rxse_pkg.sv
package rxse_pkg;

  // descriptor word 0 flag positions inside the upper half-word
  localparam int FL_EMPTY = 15;
  localparam int FL_WRAP  = 13;
  localparam int FL_LAST  = 11;
  localparam int FL_LGERR = 5;
  localparam int FL_TRUNC = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RW, S_RG, S_MOVE, S_WB, S_DRAIN
  } st_t;

  typedef enum logic [1:0] {RD_PEEK, RD_W0, RD_W1} rd_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/rxse_crc.sv
module rxse_crc (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fin
);
  import rxse_pkg::*;

  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '1;
    else if (en)    acc <= crc_step(acc, din);
  end

  assign fin = ~acc;
endmodule

// File: rtl/rxse_size.sv
module rxse_size #(
  parameter int MAX_FRAME = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        take,
  output logic        keep,
  output logic        trunc,
  output logic [15:0] stored
);
  localparam int CW       = $clog2(MAX_FRAME + 1);
  localparam int KEEP_LIM = MAX_FRAME - 4;

  logic [CW-1:0] kept;

  assign keep   = kept < CW'(KEEP_LIM);
  assign stored = 16'(kept) + 16'd4;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      kept  <= '0;
      trunc <= 1'b0;
    end else if (take) begin
      if (keep) kept  <= kept + 1'b1;
      else      trunc <= 1'b1;
    end
  end
endmodule

// File: rtl/rxse_ring.sv
module rxse_ring #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_en,
  input  logic [AW-1:0] ring_base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] DESC_STEP  = AW'(8);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0] base_al;
  assign base_al = ring_base & ALIGN_MASK;

  always_ff @(posedge clk) begin
    if (rst || !ctl_en) cur <= base_al;
    else if (adv)       cur <= wrap ? base_al : cur + DESC_STEP;
  end
endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_en,
  input  logic          rx_kick,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   max_buf,
  input  logic [15:0]   len_limit,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rx_on,
  output logic          ev_buf,
  output logic          ev_frame
);
  import rxse_pkg::*;

  localparam logic [15:0]   MB_MASK   = 16'h07F0;
  localparam logic [AW-1:0] WORD_STEP = AW'(4);
  localparam logic [AW-1:0] AL_MASK   = ~AW'(3);

  st_t           st;
  rd_t           rsel;
  logic          phase_crc, fin_q;
  logic [1:0]    crc_idx;
  logic [15:0]   dflags;
  logic [AW-1:0] bufaddr, cur;
  logic [10:0]   bcnt;
  logic [15:0]   mb;
  logic [31:0]   crc_fin;
  logic          keep, trunc, lenerr;
  logic [15:0]   stored;
  logic          frame_start, take, wr_now, last_now, full_now;
  logic [7:0]    cbyte, byte_now;
  logic [15:0]   wb_flags;

  assign mb          = max_buf & MB_MASK;
  assign s_ready     = (st == S_MOVE && !phase_crc) || st == S_DRAIN;
  assign frame_start = st == S_IDLE && ctl_en && rx_on && s_valid;
  assign take        = st == S_MOVE && !phase_crc && s_valid;
  assign cbyte       = 8'(crc_fin >> {~crc_idx, 3'b000});
  assign byte_now    = phase_crc ? cbyte : s_data;
  assign wr_now      = st == S_MOVE && (phase_crc || (s_valid && keep));
  assign last_now    = phase_crc && crc_idx == 2'd3;
  assign full_now    = {5'b0, bcnt + 11'd1} == mb;
  assign lenerr      = trunc || (stored > len_limit);

  always_comb begin
    wb_flags = dflags;
    wb_flags[FL_EMPTY] = 1'b0;
    if (fin_q) begin
      wb_flags[FL_LAST]  = 1'b1;
      wb_flags[FL_LGERR] = lenerr;
      wb_flags[FL_TRUNC] = trunc;
    end
  end

  rxse_crc u_crc (
    .clk(clk), .rst(rst), .clr(frame_start), .en(take), .din(s_data), .fin(crc_fin)
  );

  rxse_size #(.MAX_FRAME(MAX_FRAME)) u_size (
    .clk(clk), .rst(rst), .clr(frame_start), .take(take),
    .keep(keep), .trunc(trunc), .stored(stored)
  );

  rxse_ring #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ring_base(ring_base),
    .adv(st == S_WB), .wrap(dflags[FL_WRAP]), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      rsel      <= RD_PEEK;
      phase_crc <= 1'b0;
      fin_q     <= 1'b0;
      crc_idx   <= '0;
      dflags    <= '0;
      bufaddr   <= '0;
      bcnt      <= '0;
      rx_on     <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
    end else begin
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      ev_buf   <= 1'b0;
      ev_frame <= 1'b0;
      case (st)
        S_IDLE: begin
          if (frame_start) begin
            phase_crc <= 1'b0;
            crc_idx   <= '0;
            bcnt      <= '0;
            rsel      <= RD_W0;
            st        <= S_RD;
          end else if (ctl_en && !rx_on && rx_kick) begin
            rsel <= RD_PEEK;
            st   <= S_RD;
          end
        end
        S_RD: begin
          mem_rd   <= 1'b1;
          mem_addr <= (rsel == RD_W1) ? cur + WORD_STEP : cur;
          st       <= S_RW;
        end
        S_RW: st <= S_RG;
        S_RG: begin
          case (rsel)
            RD_PEEK: begin
              rx_on <= mem_rdata[16 + FL_EMPTY] && ctl_en;
              st    <= S_IDLE;
            end
            RD_W0: begin
              dflags <= mem_rdata[31:16];
              if (!mem_rdata[16 + FL_EMPTY]) begin
                if (phase_crc) begin
                  rsel <= RD_PEEK;
                  st   <= S_RD;
                end else begin
                  st <= S_DRAIN;
                end
              end else begin
                rsel <= RD_W1;
                st   <= S_RD;
              end
            end
            default: begin
              bufaddr <= mem_rdata[AW-1:0] & AL_MASK;
              st      <= S_MOVE;
            end
          endcase
        end
        S_MOVE: begin
          if (take && s_last) begin
            phase_crc <= 1'b1;
            crc_idx   <= '0;
          end
          if (phase_crc) crc_idx <= crc_idx + 2'd1;
          if (wr_now) begin
            mem_wr    <= 1'b1;
            mem_addr  <= bufaddr + AW'({bcnt[10:2], 2'b00});
            mem_be    <= 4'b0001 << bcnt[1:0];
            mem_wdata <= {4{byte_now}};
            bcnt      <= bcnt + 11'd1;
            if (last_now || full_now) begin
              fin_q <= last_now;
              st    <= S_WB;
            end
          end
        end
        S_WB: begin
          mem_wr    <= 1'b1;
          mem_be    <= 4'hF;
          mem_addr  <= cur;
          mem_wdata <= {wb_flags, 5'b0, bcnt};
          ev_buf    <= !fin_q;
          ev_frame  <= fin_q;
          bcnt      <= '0;
          rsel      <= fin_q ? RD_PEEK : RD_W0;
          st        <= S_RD;
        end
        S_DRAIN: begin
          if (s_valid && s_last) begin
            rsel <= RD_PEEK;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (!ctl_en) rx_on <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_scatter_engine_chk.sv
module rx_scatter_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctl_en,
  input logic        rx_on,
  input logic        ev_buf,
  input logic        ev_frame,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic [15:0] max_buf
);

  assert_rxon_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !rx_on);

  assert_event_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(ev_buf && ev_frame));

  assert_final_wb_R7: assert property (@(posedge clk) disable iff (rst)
    ev_frame |-> (mem_wr && mem_be == 4'hF && mem_wdata[27] && !mem_wdata[31]));

  assert_mid_wb_R8: assert property (@(posedge clk) disable iff (rst)
    ev_buf |-> (mem_wr && mem_be == 4'hF && !mem_wdata[27] && !mem_wdata[31]));

  assert_byte_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_be != 4'hF) |-> ($countones(mem_be) == 1 &&
      mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0] &&
      mem_wdata[15:8] == mem_wdata[7:0]));

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_be == 4'hF) |->
      ({5'b0, mem_wdata[10:0]} <= (max_buf & 16'h07F0) && mem_wdata[15:11] == 5'b0));

endmodule

bind rx_scatter_engine rx_scatter_engine_chk u_chk (
  .clk(clk), .rst(rst), .ctl_en(ctl_en), .rx_on(rx_on), .ev_buf(ev_buf),
  .ev_frame(ev_frame), .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .max_buf(max_buf)
);

// File: tb/sim_rx_scatter_engine.sv
`timescale 1ns/1ps
module sim_rx_scatter_engine;
  localparam int AW   = 32;
  localparam int MAXF = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_en = 1'b0, rx_kick = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [15:0] max_buf = 16'd16, len_limit = 16'hFFFF;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, mem_rd, mem_wr, rx_on, ev_buf, ev_frame;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;

  logic [31:0] mem [0:255];
  int n_cmp = 0, n_bad = 0, nbuf = 0, nfr = 0, nbuf_exp = 0, nfr_exp = 0;
  int mp = 0;
  bit armed [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_scatter_engine #(.AW(AW), .MAX_FRAME(MAXF)) u0 (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .rx_kick(rx_kick), .ring_base(ring_base),
    .max_buf(max_buf), .len_limit(len_limit), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_on(rx_on), .ev_buf(ev_buf), .ev_frame(ev_frame)
  );

  always @(posedge clk) begin
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // every clock: counted events, and every write lands in the ring or buffer area (R4)
  always @(negedge clk) begin
    if (!rst) begin
      if (ev_buf) nbuf++;
      if (ev_frame) nfr++;
      if (mem_wr)
        chk(mem_addr < 32'h20 || (mem_addr >= 32'h100 && mem_addr < 32'h200), "R4", mem_addr, 32'h100);
    end
  end

  function automatic logic [31:0] wrapbit(input int i);
    return (i == 3) ? 32'h2000_0000 : 32'h0;
  endfunction

  function automatic logic [31:0] bufa(input int i);
    return 32'h100 + 32'(i) * 32'h40;
  endfunction

  function automatic logic [7:0] membyte(input logic [31:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic kick();
    @(negedge clk); rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic arm(input logic [3:0] mask);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      armed[i] = mask[i];
      mem[2*i]   = (mask[i] ? 32'h8000_0000 : 32'h0) | wrapbit(i);
      mem[2*i+1] = bufa(i);
    end
    if (!rx_on) kick();
  endtask

  task automatic send(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = 8'(seed + i * 7); s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic run(input int n, input int seed, input int lim, input int mb, input string rq);
    logic [7:0] img[$];
    logic [31:0] c, ex;
    int kept, total, pos, chunk;
    bit tr, lg, fin, ok;
    send(n, seed);
    repeat (40) @(negedge clk);
    kept = (n > MAXF - 4) ? MAXF - 4 : n;
    tr = n > MAXF - 4;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      c = c ^ {24'h0, b};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      if (i < kept) img.push_back(b);
    end
    c = ~c;
    img.push_back(c[31:24]); img.push_back(c[23:16]);
    img.push_back(c[15:8]);  img.push_back(c[7:0]);
    total = img.size();
    lg = tr || total > lim;
    pos = 0;
    while (pos < total) begin
      if (!armed[mp]) begin
        chk(mem[2*mp] == wrapbit(mp), "R12", mem[2*mp], wrapbit(mp));
        break;
      end
      chunk = (total - pos < mb) ? total - pos : mb;
      fin = (pos + chunk == total);
      ex = wrapbit(mp) | 32'(chunk);
      if (fin) ex = ex | 32'h0800_0000 | (lg ? 32'h0020_0000 : 0) | (tr ? 32'h0001_0000 : 0);
      chk(mem[2*mp] == ex, {rq, " R7"}, mem[2*mp], ex);
      ok = 1'b1;
      for (int k = 0; k < chunk; k++)
        if (membyte(bufa(mp) + 32'(k)) != img[pos + k]) ok = 1'b0;
      chk(ok, {rq, " R4 R6"}, 32'(pos), 32'(chunk));
      armed[mp] = 1'b0;
      if (fin) nfr_exp++; else nbuf_exp++;
      pos += chunk;
      mp = (mp + 1) % 4;
    end
    chk(rx_on == armed[mp], "R11", 32'(rx_on), 32'(armed[mp]));
    chk(nbuf == nbuf_exp, "R8", 32'(nbuf), 32'(nbuf_exp));
    chk(nfr == nfr_exp, "R8", 32'(nfr), 32'(nfr_exp));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit seen;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_on == 1'b0, "R1", 32'(rx_on), 0);
    chk(s_ready == 1'b0, "R1", 32'(s_ready), 0);
    chk(mem_wr == 1'b0, "R1", 32'(mem_wr), 0);

    // R1: bytes offered with receive not enabled are refused
    ctl_en = 1'b1; s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1;
    seen = 0;
    repeat (10) begin @(negedge clk); if (s_ready) seen = 1; end
    chk(!seen, "R1", 32'(seen), 0);
    s_valid = 1'b0; s_last = 1'b0;

    // R2: kick on an occupied descriptor leaves receive disabled
    for (int i = 0; i < 8; i++) mem[i] = '0;
    kick();
    chk(rx_on == 1'b0, "R2", 32'(rx_on), 0);
    arm(4'hF);
    chk(rx_on == 1'b1, "R2", 32'(rx_on), 1);

    run(8, 3, 16'hFFFF, 16, "R4");
    run(14, 9, 16'hFFFF, 16, "R6");
    run(12, 20, 16'hFFFF, 16, "R11");

    len_limit = 16'd20;
    arm(4'hF);
    run(20, 40, 20, 16, "R10");
    len_limit = 16'hFFFF;
    arm(4'hF);
    run(50, 60, 16'hFFFF, 16, "R9");

    arm(4'(1 << mp));
    run(30, 5, 16'hFFFF, 16, "R12");

    // R3: disabling clears receive and returns the pointer to the ring start
    arm(4'hF);
    chk(rx_on == 1'b1, "R3", 32'(rx_on), 1);
    @(negedge clk); ctl_en = 1'b0;
    @(negedge clk);
    chk(rx_on == 1'b0, "R3", 32'(rx_on), 0);
    @(negedge clk); ctl_en = 1'b1;
    mp = 0;
    arm(4'hF);
    run(5, 77, 16'hFFFF, 16, "R3");

    // R5: buffer size bits outside 10:4 are ignored (0xF82B -> 32)
    max_buf = 16'hF82B;
    arm(4'hF);
    run(30, 90, 16'hFFFF, 32, "R5");

    finish_up();
  end
endmodule